// File: doc/BRIEF.md
# Freezable Circular Snapshot Buffer

This block keeps a rolling record of the most recent samples from a group of channels. On each sample strobe it stores one word per channel at the current sample index. The index advances by one per strobe and returns to zero after the last location, so the memory always holds the latest full window of samples. Each stored word occupies a 32-bit slot. The slot holds the channel's sample in its low bits and the level of the switching reference at that instant in its top bit.

A freeze request lets a host capture the window for inspection. The request is looked at only on the strobe that writes the last index of the buffer, which is the wrap point. A capture therefore always holds one unbroken run of samples, from index 0 through the final index. A thaw is honoured at a later wrap in the same way, and recording then restarts at index 0. The wrap points keep coming once per buffer's worth of strobes while the buffer is frozen. The host reads stored words through a synchronous read port addressed by sample index and channel. The port returns data only while the buffer is frozen.

Top module: `snap_ring_buffer`

## Requirements
- R1: After reset the frozen output is 0, the read data is 0, and the first sample strobe writes sample index 0.
- R2: Each sample strobe taken while thawed writes every channel's slot at the current sample index. Slot bit 31 holds the reference level. Bits SAMPLE_W-1..0 hold the channel's sample, taken from bits ch*SAMPLE_W upward of the sample bus. All other slot bits are 0.
- R3: The sample index rises by one per sample strobe and returns to 0 after index DEPTH-1. Cycles without a strobe leave it unchanged.
- R4: The freeze request is sampled only on a wrap strobe, meaning a strobe at index DEPTH-1. The frozen output then takes the request value from the next cycle on. A request at any other time has no effect.
- R5: While frozen, sample strobes write nothing, so the stored contents stay unchanged.
- R6: A thaw honoured at a wrap clears the frozen output, and the next strobe writes sample index 0.
- R7: The read address is {sample index, channel index}, with the channel in the low bits. The word appears on the read data output one cycle after the address, provided the buffer was frozen in the address cycle.
- R8: If the buffer was not frozen in the address cycle, the read data is 0 one cycle later.
- R9: A frozen buffer holds the DEPTH samples of the fill that ended at the honouring wrap, including the wrap sample itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | One-cycle strobe per sample period |
| sampleBus | input | NUM_CH*SAMPLE_W | Samples of all channels, channel 0 in the low bits |
| refPhase | input | 1 | Level of the switching reference for this sample |
| freezeReq | input | 1 | 1 requests freeze, 0 requests thaw |
| rdAddr | input | $clog2(DEPTH)+CH_W | Read address {sample index, channel} |
| rdData | output | 32 | Read slot, one cycle after the address |
| frozen | output | 1 | 1 while recording is stopped |

## Verification
The wrap strobe does two things in the same cycle. It writes the last slot of the buffer, and it decides the frozen state. A correct design keeps that final write and stops only the strobes that follow. The bench raises the freeze request a few strobes before the wrap and holds it through the wrap strobe. It then reads back the entry at index DEPTH-1 and checks that it matches the sample written on the wrap strobe. It also checks that index 0 still holds the oldest sample of that same fill.

// File: rtl/snap_ring_pkg.sv
package snap_ring_pkg;
  // strobes from the control FSM to the storage datapath
  typedef struct packed {
    logic wrEn;    // write all channel slots at wrIdx
    logic rdGate;  // buffer frozen: read port may return data
  } ctrlStrobes_t;

  localparam int SLOT_W = 32;
endpackage

// File: rtl/snap_ring_ctrl.sv
module snap_ring_ctrl
  import snap_ring_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic             freezeReq,
  output ctrlStrobes_t     strobes,
  output logic [IDX_W-1:0] wrIdx,
  output logic             frozen
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] sampIdx;
  logic             frozenQ;
  logic             wrapNow;

  assign wrapNow = sampleValid && (sampIdx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampIdx <= '0;
      frozenQ <= 1'b0;
    end else if (sampleValid) begin
      sampIdx <= wrapNow ? '0 : sampIdx + 1'b1;
      if (wrapNow) frozenQ <= freezeReq;
    end
  end

  always_comb begin
    strobes.wrEn   = sampleValid && !frozenQ;
    strobes.rdGate = frozenQ;
  end

  assign wrIdx  = sampIdx;
  assign frozen = frozenQ;

  // R4 / R6: frozen state moves only on a wrap strobe
  assert_frozen_at_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(frozenQ) |-> $past(wrapNow));

  // R3: index returns to zero after the wrap strobe
  assert_index_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrapNow |=> (sampIdx == '0));

  // R3: index holds without a strobe
  assert_index_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(sampIdx));

  // R5: no write while frozen
  assert_no_write_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    frozen |-> !strobes.wrEn);
endmodule

// File: rtl/snap_ring_store.sv
module snap_ring_store
  import snap_ring_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 18,
  parameter int DEPTH    = 512,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = IDX_W + CH_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               strobes,
  input  logic [IDX_W-1:0]           wrIdx,
  input  logic                       refPhase,
  input  logic [NUM_CH*SAMPLE_W-1:0] sampleBus,
  input  logic [ADDR_W-1:0]          rdAddr,
  output logic [SLOT_W-1:0]          rdData
);
  logic [SLOT_W-1:0] slotIn [NUM_CH];
  logic [SLOT_W-1:0] mem    [NUM_CH][DEPTH];
  logic [SLOT_W-1:0] rdWord [NUM_CH];
  logic [IDX_W-1:0]  rdSamp;
  logic [CH_W-1:0]   rdCh;
  logic [CH_W-1:0]   rdChQ;
  logic              rdGateQ;

  assign rdSamp = rdAddr[ADDR_W-1:CH_W];
  assign rdCh   = rdAddr[CH_W-1:0];

  // slot packing: reference in the top bit, sample in the low bits
  for (genvar c = 0; c < NUM_CH; c++) begin : gSlot
    assign slotIn[c] = {refPhase, {(SLOT_W-1-SAMPLE_W){1'b0}},
                        sampleBus[c*SAMPLE_W +: SAMPLE_W]};
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NUM_CH; c++) begin
      if (strobes.wrEn) mem[c][wrIdx] <= slotIn[c];
      rdWord[c] <= mem[c][rdSamp];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdChQ   <= '0;
      rdGateQ <= 1'b0;
    end else begin
      rdChQ   <= rdCh;
      rdGateQ <= strobes.rdGate;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdGateQ && (32'(rdChQ) < NUM_CH)) rdData = rdWord[rdChQ];
  end

  // R8: a read issued while thawed yields zero
  assert_thawed_read_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdGate |=> (rdData == '0));

  // R7: a frozen read does not disturb the store
  assert_frozen_no_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdGate |-> !strobes.wrEn);
endmodule

// File: rtl/snap_ring_buffer.sv
module snap_ring_buffer
  import snap_ring_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 18,
  parameter int DEPTH    = 512,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = IDX_W + CH_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic [NUM_CH*SAMPLE_W-1:0] sampleBus,
  input  logic                       refPhase,
  input  logic                       freezeReq,
  input  logic [ADDR_W-1:0]          rdAddr,
  output logic [31:0]                rdData,
  output logic                       frozen
);
  ctrlStrobes_t     strobes;
  logic [IDX_W-1:0] wrIdx;

  snap_ring_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .freezeReq   (freezeReq),
    .strobes     (strobes),
    .wrIdx       (wrIdx),
    .frozen      (frozen)
  );

  snap_ring_store #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrIdx     (wrIdx),
    .refPhase  (refPhase),
    .sampleBus (sampleBus),
    .rdAddr    (rdAddr),
    .rdData    (rdData)
  );
endmodule

// File: tb/snap_ring_buffer_bench.sv
module snap_ring_buffer_bench;
  localparam int NCH = 4;
  localparam int SW  = 18;
  localparam int DEP = 16;
  localparam int IW  = $clog2(DEP);
  localparam int CW  = $clog2(NCH);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sampleValid = 1'b0;
  logic [NCH*SW-1:0] sampleBus = '0;
  logic              refPhase = 1'b0;
  logic              freezeReq = 1'b0;
  logic [IW+CW-1:0]  rdAddr = '0;
  logic [31:0]       rdData;
  logic              frozen;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] expMem [DEP][NCH];
  int  mIdx = 0;
  bit  mFrozen = 0;

  always #2 clk = ~clk;

  snap_ring_buffer #(.NUM_CH(NCH), .SAMPLE_W(SW), .DEPTH(DEP)) u_snap_ring_buffer (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleBus(sampleBus),
    .refPhase(refPhase), .freezeReq(freezeReq), .rdAddr(rdAddr),
    .rdData(rdData), .frozen(frozen)
  );

  function automatic logic [31:0] mkSlot(logic [SW-1:0] d, logic r);
    return {r, {(31-SW){1'b0}}, d};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one sample strobe, model update, then frozen check
  task automatic pushSample(logic [NCH*SW-1:0] bus, logic r, logic frz, int gap);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleBus   = bus;
    refPhase    = r;
    freezeReq   = frz;
    if (!mFrozen)
      for (int c = 0; c < NCH; c++) expMem[mIdx][c] = mkSlot(bus[c*SW +: SW], r);
    if (mIdx == DEP - 1) mFrozen = frz;
    mIdx = (mIdx + 1) % DEP;
    @(negedge clk);
    sampleValid = 1'b0;
    freezeReq   = $urandom_range(1);
    check("R4 frozen state", {31'd0, frozen}, {31'd0, mFrozen});
    for (int g = 0; g < gap; g++) @(negedge clk);
  endtask

  function automatic logic [NCH*SW-1:0] rndBus();
    logic [NCH*SW-1:0] b;
    for (int c = 0; c < NCH; c++) b[c*SW +: SW] = SW'($urandom);
    return b;
  endfunction

  task automatic readCheck(string tag, int idx, int ch, logic [31:0] exp);
    @(negedge clk);
    rdAddr = {IW'(idx), CW'(ch)};
    @(negedge clk);
    check(tag, rdData, exp);
  endtask

  task automatic readAll(string tag);
    for (int i = 0; i < DEP; i++)
      for (int c = 0; c < NCH; c++) readCheck(tag, i, c, expMem[i][c]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 frozen after reset", {31'd0, frozen}, 32'd0);
    check("R1 read data after reset", rdData, 32'd0);

    // R3/R4: freeze request high except on wrap strobes, random gaps
    for (int n = 0; n < 2 * DEP + DEP / 2; n++)
      pushSample(rndBus(), 1'($urandom), (mIdx == DEP - 1) ? 1'b0 : 1'b1,
                 $urandom_range(3));

    // R8: thawed reads return zero
    readCheck("R8 thawed read", 0, 0, 32'd0);
    readCheck("R8 thawed read", DEP - 1, NCH - 1, 32'd0);

    // R4/R9: freeze requested before and through the wrap
    while (mIdx != 0)
      pushSample(rndBus(), 1'($urandom), (mIdx > DEP - 4) ? 1'b1 : 1'b0, 0);
    check("R4 frozen set at wrap", {31'd0, frozen}, 32'd1);

    // R2/R7/R9: whole frozen window, incl. wrap sample at DEP-1
    readAll("R7 R9 frozen contents");

    // R5: strobes while frozen do not write
    for (int n = 0; n < DEP / 2; n++)
      pushSample(rndBus(), 1'($urandom), 1'($urandom), $urandom_range(2));
    readAll("R5 contents unchanged while frozen");

    // R6: thaw at next wrap, then directed pattern at index 0
    while (mIdx != 0)
      pushSample(rndBus(), 1'($urandom), (mIdx == DEP - 1) ? 1'b0 : 1'b1, 0);
    check("R6 frozen cleared at wrap", {31'd0, frozen}, 32'd0);
    pushSample({NCH{SW'(18'h2a5a5)}}, 1'b1, 1'b0, 0);
    pushSample({NCH{SW'(18'h3ffff)}}, 1'b0, 1'b0, 1);
    for (int n = 2; n < DEP; n++)
      pushSample(rndBus(), 1'($urandom), (mIdx == DEP - 1) ? 1'b1 : 1'b0,
                 $urandom_range(2));
    check("R4 refrozen", {31'd0, frozen}, 32'd1);
    // R2/R6: first post-thaw sample landed at index 0
    readCheck("R6 R2 index0 after thaw", 0, 2, mkSlot(18'h2a5a5, 1'b1));
    readCheck("R2 all-ones sample", 1, 3, mkSlot(18'h3ffff, 1'b0));
    readAll("R2 R3 random window");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule